// File: doc/BRIEF.md
# External Memory Bus Port Mux

This block lets an 8-bit CPU reach external data memory through general-purpose port pins it does not own. When the CPU requests an off-chip data transfer, the block takes over four port bytes for that one transfer. It drives the address, the data (for writes), an active-low read strobe, an active-low write strobe and, in multiplexed addressing, an address-latch strobe. When the transfer ends, every pin returns to the value and enable held in its port latch. Software normally parks the latches at idle levels, such as strobes high.

Four configuration fields control the block. The memory mode picks on-chip only, split, split with a bank register, or off-chip only. A 16-bit boundary divides on-chip from off-chip addresses in the split modes. An 8-bit bank value supplies the upper address byte in the banked split mode. The addressing flag picks multiplexed or non-multiplexed addressing. The CPU request side is a valid/ready channel. The requester presents address, write data and direction with `req_valid` and holds them until `req_ready` is seen high at a clock edge. Once that handshake completes, all request fields and the configuration are captured, and the requester may change them. `req_ready` is high only when the block is idle, so a new request waits until the previous one has been answered. The answer is a one-cycle `rsp_valid` pulse with no back-pressure.

The block supplies only a value and an enable per pin. Whether a pad is push-pull or open-drain stays with the pad logic.

Top module: `xmem_pin_bridge`

## Requirements
- R1: While no transfer is in progress, `req_ready` is 1, every bit of `pin_out` equals `port_latch` and every bit of `pin_oe` equals `port_drive`.
- R2: A request served on chip leaves every pin at its latch value and enable. The response comes in the cycle after acceptance, with `rsp_valid`=1 and `rsp_local`=1.
- R3: Memory mode encoding is 0 on-chip only, 1 split, 2 split with bank, 3 off-chip only. A request goes off chip in mode 3, and in modes 1 and 2 when its address is greater than or equal to `cfg_boundary`. Every other request is served on chip.
- R4: During an off-chip transfer, port byte 2 (pins 23:16) is driven with the upper address byte. In mode 2 that byte is `cfg_bank`; in modes 1 and 3 it is address bits 15:8.
- R5: The write strobe is control-port pin 7 and the read strobe is pin 6. Both are active low and driven for the whole transfer, and they are never low together. The strobe for the transfer's direction is low for exactly STROBE_W cycles.
- R6: In multiplexed mode (`cfg_mux`=1), pin 3 carries the address-latch strobe. It is high in the first transfer cycle and low in the second. In both cycles the low address byte is on the data byte (pins 31:24). Port byte 1 stays at its latch value. The strobe phase follows.
- R7: In non-multiplexed mode, pin 3 stays at its latch value. Port byte 1 (pins 15:8) carries the low address byte for the whole transfer, and one address cycle precedes the strobe phase.
- R8: In a read, the data byte's enables are 0 in every cycle except multiplexed address cycles. `rsp_rdata` takes the value on `dbus_in` in the last cycle the read strobe is low, which is the rising edge of the read strobe.
- R9: In a write, the data byte carries the write data, with enables 1, from the end of the address phase through the strobe cycles and one further cycle after the write strobe rises.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the strobe rises. In the next cycle the pins are released and `req_ready` is 1.
- R11: `req_ready` is 0 from acceptance until the response pulse ends. Changing the request inputs after acceptance does not alter the transfer in progress.
- R12: Control-port pins other than 7, 6 and, in multiplexed mode, 3 keep their latch value and enable during transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux | input | 1 | 1 = multiplexed address/data |
| cfg_mode | input | 2 | Memory mode (see R3) |
| cfg_boundary | input | 16 | First off-chip address in split modes |
| cfg_bank | input | 8 | Upper address byte in banked split mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_local | output | 1 | Done pulse was for an on-chip request |
| rsp_rdata | output | 8 | Data captured on an off-chip read |
| port_latch | input | 32 | Latch value for each pin of four port bytes |
| port_drive | input | 32 | Latch enable for each pin |
| dbus_in | input | 8 | Data pins as seen from the pads |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |

## Verification
A sequencer stuck in a wrong phase shows up within one cycle. The pins stay seized while `req_ready` is high, or a strobe is low for a cycle too few or too many. A decode fault in the routing shows up in the first cycle after acceptance. The pins move when they should stay still, or the wrong upper address byte appears. A capture made on the wrong edge returns the inverted pattern the bench places on the data pins outside the strobe window. This shows in `rsp_rdata` during the done pulse.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    MM_ONCHIP     = 2'd0,
    MM_SPLIT      = 2'd1,
    MM_SPLIT_BANK = 2'd2,
    MM_OFFCHIP    = 2'd3
  } mem_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOCAL,
    PH_ALE_HI,
    PH_ALE_LO,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // port byte roles on the shared pin vector
  localparam int PORT_CTL = 0;
  localparam int PORT_ALO = 1;
  localparam int PORT_AHI = 2;
  localparam int PORT_DAT = 3;
  localparam int NUM_PORTS = 4;

  // fixed control pins within the control byte
  localparam int CTL_WR_BIT  = 7;
  localparam int CTL_RD_BIT  = 6;
  localparam int CTL_ALE_BIT = 3;

endpackage

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] boundary,
  input  logic [DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              offchip,
  output logic [ADDR_W-1:0] bus_addr
);

  mem_mode_e mode_e;
  logic      above;

  assign mode_e = mem_mode_e'(mode);
  assign above  = (cpu_addr >= boundary);

  always_comb begin
    offchip  = 1'b0;
    bus_addr = cpu_addr;
    unique case (mode_e)
      MM_ONCHIP:     offchip = 1'b0;
      MM_SPLIT:      offchip = above;
      MM_SPLIT_BANK: begin
        offchip  = above;
        bus_addr = {bank, cpu_addr[DATA_W-1:0]};
      end
      MM_OFFCHIP:    offchip = 1'b1;
      default:       offchip = 1'b0;
    endcase
  end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int STROBE_W = 2,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int CNT_W    = (STROBE_W > 1) ? $clog2(STROBE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_mux,
  input  logic              req_offchip,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] data_in,
  output logic              req_ready,
  output phase_e            phase,
  output logic              xfer_we,
  output logic              xfer_mux,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [DATA_W-1:0] xfer_wdata,
  output logic              rsp_valid,
  output logic              rsp_local,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q;
  logic              mux_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      mux_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            we_q    <= req_we;
            mux_q   <= req_mux;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (!req_offchip)  phase_q <= PH_LOCAL;
            else if (req_mux)  phase_q <= PH_ALE_HI;
            else               phase_q <= PH_SETUP;
          end
        end
        PH_LOCAL:  phase_q <= PH_IDLE;
        PH_ALE_HI: phase_q <= PH_ALE_LO;
        PH_ALE_LO, PH_SETUP: begin
          phase_q <= PH_STROBE;
          cnt_q   <= STROBE_LAST;
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            if (!we_q) rdata_q <= data_in;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD:   phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign req_ready  = (phase_q == PH_IDLE);
  assign xfer_we    = we_q;
  assign xfer_mux   = mux_q;
  assign xfer_addr  = addr_q;
  assign xfer_wdata = wdata_q;
  assign rsp_valid  = (phase_q == PH_HOLD) || (phase_q == PH_LOCAL);
  assign rsp_local  = (phase_q == PH_LOCAL);
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/xmem_pinmux.sv
module xmem_pinmux
  import xmem_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int PINS_W = NUM_PORTS * DATA_W
) (
  input  phase_e            phase,
  input  logic              xfer_we,
  input  logic              xfer_mux,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic [PINS_W-1:0] port_latch,
  input  logic [PINS_W-1:0] port_drive,
  output logic [PINS_W-1:0] pin_out,
  output logic [PINS_W-1:0] pin_oe
);

  localparam int CTL_LSB = PORT_CTL * DATA_W;
  localparam int ALO_LSB = PORT_ALO * DATA_W;
  localparam int AHI_LSB = PORT_AHI * DATA_W;
  localparam int DAT_LSB = PORT_DAT * DATA_W;

  logic engaged;
  logic strobe;
  logic addr_cyc;

  assign engaged  = (phase != PH_IDLE) && (phase != PH_LOCAL);
  assign strobe   = (phase == PH_STROBE);
  assign addr_cyc = (phase == PH_ALE_HI) || (phase == PH_ALE_LO);

  always_comb begin
    pin_out = port_latch;
    pin_oe  = port_drive;
    if (engaged) begin
      // strobes, active low
      pin_out[CTL_LSB + CTL_WR_BIT] = ~(strobe & xfer_we);
      pin_oe [CTL_LSB + CTL_WR_BIT] = 1'b1;
      pin_out[CTL_LSB + CTL_RD_BIT] = ~(strobe & ~xfer_we);
      pin_oe [CTL_LSB + CTL_RD_BIT] = 1'b1;
      if (xfer_mux) begin
        pin_out[CTL_LSB + CTL_ALE_BIT] = (phase == PH_ALE_HI);
        pin_oe [CTL_LSB + CTL_ALE_BIT] = 1'b1;
      end
      // upper address byte
      pin_out[AHI_LSB +: DATA_W] = xfer_addr[ADDR_W-1:DATA_W];
      pin_oe [AHI_LSB +: DATA_W] = '1;
      // dedicated low address byte only without multiplexing
      if (!xfer_mux) begin
        pin_out[ALO_LSB +: DATA_W] = xfer_addr[DATA_W-1:0];
        pin_oe [ALO_LSB +: DATA_W] = '1;
      end
      // shared data byte
      if (xfer_mux && addr_cyc) begin
        pin_out[DAT_LSB +: DATA_W] = xfer_addr[DATA_W-1:0];
        pin_oe [DAT_LSB +: DATA_W] = '1;
      end else if (xfer_we) begin
        pin_out[DAT_LSB +: DATA_W] = xfer_wdata;
        pin_oe [DAT_LSB +: DATA_W] = '1;
      end else begin
        pin_oe [DAT_LSB +: DATA_W] = '0;
      end
    end
  end

endmodule

// File: rtl/xmem_pin_bridge.sv
module xmem_pin_bridge
  import xmem_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int STROBE_W = 2,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int PINS_W   = NUM_PORTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mux,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_boundary,
  input  logic [DATA_W-1:0] cfg_bank,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_local,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [PINS_W-1:0] port_latch,
  input  logic [PINS_W-1:0] port_drive,
  input  logic [DATA_W-1:0] dbus_in,
  output logic [PINS_W-1:0] pin_out,
  output logic [PINS_W-1:0] pin_oe
);

  logic              route_off;
  logic [ADDR_W-1:0] route_addr;
  phase_e            phase;
  logic              xfer_we;
  logic              xfer_mux;
  logic [ADDR_W-1:0] xfer_addr;
  logic [DATA_W-1:0] xfer_wdata;

  xmem_route #(.DATA_W(DATA_W)) u_route (
    .mode     (cfg_mode),
    .boundary (cfg_boundary),
    .bank     (cfg_bank),
    .cpu_addr (req_addr),
    .offchip  (route_off),
    .bus_addr (route_addr)
  );

  xmem_seq #(.DATA_W(DATA_W), .STROBE_W(STROBE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_mux     (cfg_mux),
    .req_offchip (route_off),
    .req_addr    (route_addr),
    .req_wdata   (req_wdata),
    .data_in     (dbus_in),
    .req_ready   (req_ready),
    .phase       (phase),
    .xfer_we     (xfer_we),
    .xfer_mux    (xfer_mux),
    .xfer_addr   (xfer_addr),
    .xfer_wdata  (xfer_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_local   (rsp_local),
    .rsp_rdata   (rsp_rdata)
  );

  xmem_pinmux #(.DATA_W(DATA_W)) u_pins (
    .phase      (phase),
    .xfer_we    (xfer_we),
    .xfer_mux   (xfer_mux),
    .xfer_addr  (xfer_addr),
    .xfer_wdata (xfer_wdata),
    .port_latch (port_latch),
    .port_drive (port_drive),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk
  import xmem_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PINS_W = NUM_PORTS * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_local,
  input logic [PINS_W-1:0] port_latch,
  input logic [PINS_W-1:0] port_drive,
  input logic [PINS_W-1:0] pin_out,
  input logic [PINS_W-1:0] pin_oe
);

  localparam int WR  = PORT_CTL * DATA_W + CTL_WR_BIT;
  localparam int RD  = PORT_CTL * DATA_W + CTL_RD_BIT;
  localparam int DAT = PORT_DAT * DATA_W;

  logic offchip_busy;
  assign offchip_busy = !req_ready && !rsp_local;

  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pin_out == port_latch) && (pin_oe == port_drive));

  a_r2_local_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_local) |-> (pin_out == port_latch) && (pin_oe == port_drive));

  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    offchip_busy |-> (pin_out[WR] || pin_out[RD]));

  a_r8_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    (offchip_busy && !pin_out[RD]) |-> (pin_oe[DAT +: DATA_W] == '0));

  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready) && $rose(pin_out[WR]))
      |-> (pin_oe[DAT +: DATA_W] == '1) && $stable(pin_out[DAT +: DATA_W]));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind xmem_pin_bridge xmem_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_local  (rsp_local),
  .port_latch (port_latch),
  .port_drive (port_drive),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/sim_xmem_pin_bridge.sv
module sim_xmem_pin_bridge;

  localparam int SW = 2;
  localparam logic [15:0] BND  = 16'h4000;
  localparam logic [7:0]  BANK = 8'h9C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mux = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_boundary = BND;
  logic [7:0]  cfg_bank = BANK;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_local;
  logic [7:0]  rsp_rdata;
  logic [31:0] port_latch = 32'hFFFF_FFFF;
  logic [31:0] port_drive = 32'h0000_00C8;
  logic [7:0]  dbus_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xmem_pin_bridge #(.DATA_W(8), .STROBE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_mode(cfg_mode),
    .cfg_boundary(cfg_boundary), .cfg_bank(cfg_bank),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_local(rsp_local), .rsp_rdata(rsp_rdata),
    .port_latch(port_latch), .port_drive(port_drive), .dbus_in(dbus_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [7:0] hi, input logic [7:0] lo);
    return (lo ^ {hi[3:0], hi[7:4]}) + 8'h3D;
  endfunction

  function automatic logic [63:0] exp_pins(input logic off, input logic mux, input logic we,
                                            input int k, input int pre, input logic [15:0] addr,
                                            input logic [7:0] hi, input logic [7:0] wd,
                                            input logic [31:0] latch, input logic [31:0] drv);
    logic [31:0] o;
    logic [31:0] e;
    logic        stb;
    o = latch;
    e = drv;
    if (off) begin
      stb = (k >= pre) && (k < pre + SW);
      o[7] = !(stb && we);  e[7] = 1'b1;
      o[6] = !(stb && !we); e[6] = 1'b1;
      if (mux) begin o[3] = (k == 0); e[3] = 1'b1; end
      o[23:16] = hi; e[23:16] = 8'hFF;
      if (!mux) begin o[15:8] = addr[7:0]; e[15:8] = 8'hFF; end
      if (mux && k < 2) begin o[31:24] = addr[7:0]; e[31:24] = 8'hFF; end
      else if (we) begin o[31:24] = wd; e[31:24] = 8'hFF; end
      else e[31:24] = 8'h00;
    end
    return {o, e};
  endfunction

  task automatic run_access(input logic [1:0] mode, input logic mux, input logic [15:0] addr,
                            input logic we, input logic [7:0] wd,
                            input logic [31:0] latch, input logic [31:0] drv);
    logic       off;
    logic [7:0] hi;
    logic [7:0] mv;
    int         pre;
    int         n;
    string      tag;
    off = (mode == 2'd3) || ((mode == 2'd1 || mode == 2'd2) && addr >= BND);
    hi  = (mode == 2'd2) ? BANK : addr[15:8];
    mv  = mem_val(hi, addr[7:0]);
    pre = mux ? 2 : 1;
    n   = off ? pre + SW + 1 : 1;

    @(negedge clk);
    cfg_mode = mode; cfg_mux = mux; port_latch = latch; port_drive = drv;
    req_addr = addr; req_we = we; req_wdata = wd; req_valid = 1'b1;
    dbus_in = ~mv;
    #1;
    check("R1 idle pins", {pin_out, pin_oe}, {latch, drv});
    check("R1 ready idle", {63'd0, req_ready}, 64'd1);
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd; req_we = ~we;
      dbus_in = (off && k >= pre && k < pre + SW) ? mv : ~mv;
      #1;
      if (!off)                  tag = "R2 local pins";
      else if (k < pre)          tag = mux ? "R6 mux address" : "R7 plain address";
      else if (k < pre + SW)     tag = "R5 strobe";
      else                       tag = we ? "R9 write hold" : "R8 read turnaround";
      check(tag, {pin_out, pin_oe},
            exp_pins(off, mux, we, k, pre, addr, hi, wd, latch, drv));
      check("R11 busy", {63'd0, req_ready}, 64'd0);
      check("R10 done timing", {62'd0, rsp_valid, rsp_local},
            {62'd0, (k == n - 1), (k == n - 1) && !off});
      if (k == 0) begin
        check("R3 route", {63'd0, rsp_local}, {63'd0, !off});
        if (off) begin
          check("R4 upper byte", {56'd0, pin_out[23:16]}, {56'd0, hi});
          check("R12 ctrl others", {56'd0, pin_out[7:0] & 8'h37}, {56'd0, latch[7:0] & 8'h37});
        end
      end
      if (off && !we && k == n - 1)
        check("R8 read capture", {56'd0, rsp_rdata}, {56'd0, mv});
    end
    @(negedge clk);
    #1;
    check("R10 release", {pin_out, pin_oe}, {latch, drv});
    check("R10 ready back", {62'd0, req_ready, rsp_valid}, {62'd0, 1'b1, 1'b0});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addr;
    logic [31:0] latch;
    int          idx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pins", {pin_out, pin_oe}, {port_latch, port_drive});
    check("R10 reset no done", {62'd0, req_ready, rsp_valid}, {62'd0, 1'b1, 1'b0});
    rst_n = 1'b1;
    idx = 0;
    for (int mode = 0; mode < 4; mode++)
      for (int mux = 0; mux < 2; mux++)
        for (int we = 0; we < 2; we++)
          for (int ai = 0; ai < 4; ai++) begin
            case (ai)
              0: addr = 16'h0000;
              1: addr = BND - 16'd1;
              2: addr = BND;
              default: addr = 16'hC3A5 ^ 16'(idx);
            endcase
            latch = 32'h6B2E_D417 + 32'h0101_0101 * 32'(idx);
            run_access(2'(mode), mux[0], addr, we[0], 8'h5A ^ 8'(idx * 7),
                       latch, ~latch ^ 32'h00FF_00FF);
            idx++;
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule